// File: doc/BRIEF.md
# Guest Interrupt Exit Logic

This block sits beside a core that runs a virtualized guest. It decides when an interrupt-related condition must hand control back to the hypervisor. It tracks whether the core is in guest mode. While it is, the block watches three sources of exit, each under its own control bit:

- an external interrupt request;
- a guest write that lowers a shadow copy of the task-priority value below a programmed threshold;
- the guest becoming able to accept maskable interrupts.

It reports one reason per exit. After an exit it leaves guest mode and ignores every cause until the next entry.

The block also keeps the guest's interruptibility state. This state holds two blocks: a temporary block after a stack-segment load, which the next retired instruction clears, and a block that lasts while an earlier NMI is being handled. The block also holds the task-priority shadow that guest writes update. On each entry the hypervisor supplies the starting shadow value, the starting interruptibility state and an optional event to inject. The injected event appears on the first guest cycle, as if it had arrived just after the entry.

Top module: `gvx_intr_exit`

## Requirements
- R1: After reset: guest mode off, exit request low, exit reason 0, shadow 0, interruptibility state 0, injection valid low.
- R2: An entry strobe while outside guest mode sets guest mode at the next edge. At that edge the shadow loads from the entry priority value, the state loads from the entry state (bit 0 = stack-load block, bit 1 = NMI block), and the exit reason clears to 0.
- R3: In guest mode, with external-interrupt exiting set, a pending external interrupt raises an exit with reason 1 at the next edge, even when the guest enable flag is 0. With that control clear, the interrupt causes no exit.
- R4: In guest mode, with window exiting set, an exit with reason 3 is raised at the next edge once the guest enable flag is 1 and the stack-load block is 0. An enable flag of 0 blocks it.
- R5: A retired instruction flagged as a stack-segment load sets state bit 0. The next retired instruction without that flag clears it.
- R6: An NMI-taken pulse sets state bit 1. An NMI-return pulse clears it.
- R7: With the priority-shadow control set, a retired priority write stores its 4-bit value in the shadow. With the control clear, the write leaves the shadow unchanged and causes no exit.
- R8: A shadow write raises an exit with reason 2 only when the new value is below both the threshold and the old shadow value. An unchanged or raised value never exits.
- R9: When several causes hold in one cycle, the reported reason is external (1) over priority (2) over window (3).
- R10: The exit request is a one-cycle pulse that leaves guest mode. The reason holds until the next entry. No cause raises an exit outside guest mode.
- R11: An entry that carries an injection drives injection valid, vector and type for exactly the first guest cycle. An entry without one drives nothing.
- R12: An entry strobe while already in guest mode is ignored: the shadow, the state and the injection outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| entry_stb | input | 1 | Request to enter guest mode |
| entry_tpr | input | 4 | Shadow value loaded on entry |
| entry_istate | input | 2 | Interruptibility state loaded on entry |
| entry_inj_vld | input | 1 | Entry carries an event to inject |
| entry_inj_vec | input | 8 | Vector of the injected event |
| entry_inj_type | input | 3 | Kind of the injected event |
| ctl_ext_exit | input | 1 | External-interrupt exiting control |
| ctl_win_exit | input | 1 | Interrupt-window exiting control |
| ctl_tpr_shadow | input | 1 | Priority-shadow control |
| tpr_threshold | input | 4 | Priority threshold |
| guest_ie | input | 1 | Guest interrupt-enable flag |
| ext_irq | input | 1 | External interrupt pending |
| retire_stb | input | 1 | A guest instruction retired |
| retire_ss_load | input | 1 | The retired instruction loaded the stack segment |
| retire_tpr_wr | input | 1 | The retired instruction wrote the priority register |
| retire_tpr_val | input | 4 | Value written by that instruction |
| nmi_taken | input | 1 | Guest began handling an NMI |
| nmi_return | input | 1 | Guest finished handling an NMI |
| in_guest | output | 1 | Guest mode active |
| exit_req | output | 1 | Exit pulse |
| exit_reason | output | 2 | 0 none, 1 external, 2 priority, 3 window |
| tpr_shadow | output | 4 | Current priority shadow |
| istate | output | 2 | Interruptibility state (bit 0 stack-load, bit 1 NMI) |
| inj_valid | output | 1 | Injection delivered this cycle |
| inj_vec | output | 8 | Injected vector |
| inj_type | output | 3 | Injected kind |

## Verification
The hardest situation to reach is a window exit that the stack-load block has held back. The block must hold while the guest enable flag is already 1, and the exit must appear only on the cycle after the next plain instruction retires. The bench sets the block through a flagged retirement with the window control armed. It then checks that no exit occurs while the enable flag is high, retires one plain instruction, and checks that the exit lands exactly one edge later. Priority ties are reached by placing a lowering priority write in the first guest cycle, while the window is already open.

// File: rtl/gvx_pkg.sv
// Shared types for the guest interrupt exit logic.
// Assumes: reason codes are fixed by the exit-handler contract.
package gvx_pkg;
    typedef enum logic [1:0] {
        RSN_NONE = 2'd0,
        RSN_EXT  = 2'd1,
        RSN_TPR  = 2'd2,
        RSN_WIN  = 2'd3
    } exit_rsn_t;
endpackage

// File: rtl/gvx_cause_eval.sv
// Evaluates the exit causes of the current cycle and picks one reason.
// Assumes: inputs are stable within the cycle; the caller gates on guest mode.
module gvx_cause_eval
    import gvx_pkg::*;
#(
    parameter int TPR_W = 4
) (
    input  logic             in_guest,
    input  logic             ctl_ext_exit,
    input  logic             ctl_win_exit,
    input  logic             ext_irq,
    input  logic             guest_ie,
    input  logic             ss_blk,
    input  logic             tpr_wr_fire,
    input  logic [TPR_W-1:0] tpr_new,
    input  logic [TPR_W-1:0] tpr_old,
    input  logic [TPR_W-1:0] tpr_thr,
    output logic             cause_any,
    output exit_rsn_t        cause_rsn
);
    logic ext_c;
    logic tpr_c;
    logic win_c;

    // Raw causes: a priority drop needs a lower value that also falls under the threshold.
    always_comb begin
        ext_c = in_guest && ctl_ext_exit && ext_irq;
        tpr_c = in_guest && tpr_wr_fire && (tpr_new < tpr_thr) && (tpr_new < tpr_old);
        win_c = in_guest && ctl_win_exit && guest_ie && !ss_blk;
    end

    // Fixed priority: external, then priority drop, then window.
    always_comb begin
        cause_any = ext_c || tpr_c || win_c;
        if (ext_c)      cause_rsn = RSN_EXT;
        else if (tpr_c) cause_rsn = RSN_TPR;
        else if (win_c) cause_rsn = RSN_WIN;
        else            cause_rsn = RSN_NONE;
    end
endmodule

// File: rtl/gvx_tpr_shadow.sv
// Holds the guest task-priority shadow.
// Assumes: an entry load and a guest write never coincide (the write applies only in guest mode).
module gvx_tpr_shadow #(
    parameter int TPR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TPR_W-1:0] load_val,
    input  logic             wr,
    input  logic [TPR_W-1:0] wr_val,
    output logic [TPR_W-1:0] shadow
);
    // Shadow register: entry load first, then guest write.
    always_ff @(posedge clk) begin
        if (!rst_n)    shadow <= '0;
        else if (load) shadow <= load_val;
        else if (wr)   shadow <= wr_val;
    end
endmodule

// File: rtl/gvx_intr_state.sv
// Tracks the guest interruptibility state: a stack-load block and an NMI block.
// Assumes: event inputs are qualified by 'active' (guest mode) inside this module.
module gvx_intr_state #(
    parameter int ST_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic            load,
    input  logic [ST_W-1:0] load_val,
    input  logic            retire_stb,
    input  logic            retire_ss_load,
    input  logic            nmi_taken,
    input  logic            nmi_return,
    output logic            ss_blk,
    output logic            nmi_blk
);
    // Stack-load block: set by a flagged retirement, cleared by the next plain one.
    always_ff @(posedge clk) begin
        if (!rst_n)                    ss_blk <= 1'b0;
        else if (load)                 ss_blk <= load_val[0];
        else if (active && retire_stb) ss_blk <= retire_ss_load;
    end

    // NMI block: set on NMI entry and cleared on its return; entry wins a tie.
    always_ff @(posedge clk) begin
        if (!rst_n)                    nmi_blk <= 1'b0;
        else if (load)                 nmi_blk <= load_val[1];
        else if (active && nmi_taken)  nmi_blk <= 1'b1;
        else if (active && nmi_return) nmi_blk <= 1'b0;
    end
endmodule

// File: rtl/gvx_inject.sv
// Presents the hypervisor-chosen event on the first guest cycle.
// Assumes: 'accept' pulses for one cycle when an entry is taken.
module gvx_inject #(
    parameter int VEC_W  = 8,
    parameter int TYPE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              req_vld,
    input  logic [VEC_W-1:0]  req_vec,
    input  logic [TYPE_W-1:0] req_type,
    output logic              inj_valid,
    output logic [VEC_W-1:0]  inj_vec,
    output logic [TYPE_W-1:0] inj_type
);
    // One-cycle delivery pulse with its payload; the payload is zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inj_valid <= 1'b0;
            inj_vec   <= '0;
            inj_type  <= '0;
        end else if (accept && req_vld) begin
            inj_valid <= 1'b1;
            inj_vec   <= req_vec;
            inj_type  <= req_type;
        end else begin
            inj_valid <= 1'b0;
            inj_vec   <= '0;
            inj_type  <= '0;
        end
    end
endmodule

// File: rtl/gvx_intr_exit.sv
// Top: guest mode tracking, exit decision and event injection for a virtualized guest.
// Assumes: one retired instruction per cycle at most; strobes last one cycle.
module gvx_intr_exit
    import gvx_pkg::*;
#(
    parameter int TPR_W  = 4,
    parameter int VEC_W  = 8,
    parameter int TYPE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              entry_stb,
    input  logic [TPR_W-1:0]  entry_tpr,
    input  logic [1:0]        entry_istate,
    input  logic              entry_inj_vld,
    input  logic [VEC_W-1:0]  entry_inj_vec,
    input  logic [TYPE_W-1:0] entry_inj_type,
    input  logic              ctl_ext_exit,
    input  logic              ctl_win_exit,
    input  logic              ctl_tpr_shadow,
    input  logic [TPR_W-1:0]  tpr_threshold,
    input  logic              guest_ie,
    input  logic              ext_irq,
    input  logic              retire_stb,
    input  logic              retire_ss_load,
    input  logic              retire_tpr_wr,
    input  logic [TPR_W-1:0]  retire_tpr_val,
    input  logic              nmi_taken,
    input  logic              nmi_return,
    output logic              in_guest,
    output logic              exit_req,
    output logic [1:0]        exit_reason,
    output logic [TPR_W-1:0]  tpr_shadow,
    output logic [1:0]        istate,
    output logic              inj_valid,
    output logic [VEC_W-1:0]  inj_vec,
    output logic [TYPE_W-1:0] inj_type
);
    localparam int ST_W = 2;

    logic      entry_acc;
    logic      tpr_wr_fire;
    logic      cause_any;
    exit_rsn_t cause_rsn;
    logic      exit_fire;
    logic      ss_blk;
    logic      nmi_blk;

    // Qualify the entry and the shadow write.
    always_comb begin
        entry_acc   = entry_stb && !in_guest;
        tpr_wr_fire = in_guest && ctl_tpr_shadow && retire_stb && retire_tpr_wr;
        exit_fire   = in_guest && cause_any;
        istate      = {nmi_blk, ss_blk};
    end

    gvx_cause_eval #(.TPR_W(TPR_W)) u_cause (
        .in_guest     (in_guest),
        .ctl_ext_exit (ctl_ext_exit),
        .ctl_win_exit (ctl_win_exit),
        .ext_irq      (ext_irq),
        .guest_ie     (guest_ie),
        .ss_blk       (ss_blk),
        .tpr_wr_fire  (tpr_wr_fire),
        .tpr_new      (retire_tpr_val),
        .tpr_old      (tpr_shadow),
        .tpr_thr      (tpr_threshold),
        .cause_any    (cause_any),
        .cause_rsn    (cause_rsn)
    );

    gvx_tpr_shadow #(.TPR_W(TPR_W)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (entry_acc),
        .load_val (entry_tpr),
        .wr       (tpr_wr_fire),
        .wr_val   (retire_tpr_val),
        .shadow   (tpr_shadow)
    );

    gvx_intr_state #(.ST_W(ST_W)) u_istate (
        .clk            (clk),
        .rst_n          (rst_n),
        .active         (in_guest),
        .load           (entry_acc),
        .load_val       (entry_istate),
        .retire_stb     (retire_stb),
        .retire_ss_load (retire_ss_load),
        .nmi_taken      (nmi_taken),
        .nmi_return     (nmi_return),
        .ss_blk         (ss_blk),
        .nmi_blk        (nmi_blk)
    );

    gvx_inject #(.VEC_W(VEC_W), .TYPE_W(TYPE_W)) u_inject (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (entry_acc),
        .req_vld   (entry_inj_vld),
        .req_vec   (entry_inj_vec),
        .req_type  (entry_inj_type),
        .inj_valid (inj_valid),
        .inj_vec   (inj_vec),
        .inj_type  (inj_type)
    );

    // Guest mode: set by an accepted entry, cleared by an exit.
    always_ff @(posedge clk) begin
        if (!rst_n)         in_guest <= 1'b0;
        else if (entry_acc) in_guest <= 1'b1;
        else if (exit_fire) in_guest <= 1'b0;
    end

    // Exit pulse and sticky reason, cleared on the next entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exit_req    <= 1'b0;
            exit_reason <= RSN_NONE;
        end else begin
            exit_req <= exit_fire;
            if (exit_fire)      exit_reason <= cause_rsn;
            else if (entry_acc) exit_reason <= RSN_NONE;
        end
    end
endmodule

// File: rtl/gvx_intr_exit_chk.sv
// Property checker for gvx_intr_exit, bound to every instance.
module gvx_intr_exit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       entry_stb,
    input logic       ctl_ext_exit,
    input logic       ext_irq,
    input logic       in_guest,
    input logic       exit_req,
    input logic [1:0] exit_reason,
    input logic       inj_valid
);
    // R10
    exit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req |=> !exit_req);
    // R10
    exit_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req |-> (!in_guest && exit_reason != 2'd0));
    // R10
    stay_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_guest && !entry_stb) |=> (!in_guest && !exit_req));
    // R3
    ext_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_guest && ctl_ext_exit && ext_irq) |=> (exit_req && exit_reason == 2'd1));
    // R2
    entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_guest && entry_stb) |=> in_guest);
    // R11
    inject_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inj_valid |-> $rose(in_guest));
endmodule

bind gvx_intr_exit gvx_intr_exit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .entry_stb   (entry_stb),
    .ctl_ext_exit(ctl_ext_exit),
    .ext_irq     (ext_irq),
    .in_guest    (in_guest),
    .exit_req    (exit_req),
    .exit_reason (exit_reason),
    .inj_valid   (inj_valid)
);

// File: tb/gvx_intr_exit_tb.sv
`timescale 1ns/1ps
module gvx_intr_exit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       entry_stb = 0;
    logic [3:0] entry_tpr = 0;
    logic [1:0] entry_istate = 0;
    logic       entry_inj_vld = 0;
    logic [7:0] entry_inj_vec = 0;
    logic [2:0] entry_inj_type = 0;
    logic       ctl_ext_exit = 0, ctl_win_exit = 0, ctl_tpr_shadow = 0;
    logic [3:0] tpr_threshold = 0;
    logic       guest_ie = 0, ext_irq = 0;
    logic       retire_stb = 0, retire_ss_load = 0, retire_tpr_wr = 0;
    logic [3:0] retire_tpr_val = 0;
    logic       nmi_taken = 0, nmi_return = 0;
    logic       in_guest, exit_req;
    logic [1:0] exit_reason;
    logic [3:0] tpr_shadow;
    logic [1:0] istate;
    logic       inj_valid;
    logic [7:0] inj_vec;
    logic [2:0] inj_type;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gvx_intr_exit u_dut (
        .clk(clk), .rst_n(rst_n), .entry_stb(entry_stb), .entry_tpr(entry_tpr),
        .entry_istate(entry_istate), .entry_inj_vld(entry_inj_vld),
        .entry_inj_vec(entry_inj_vec), .entry_inj_type(entry_inj_type),
        .ctl_ext_exit(ctl_ext_exit), .ctl_win_exit(ctl_win_exit),
        .ctl_tpr_shadow(ctl_tpr_shadow), .tpr_threshold(tpr_threshold),
        .guest_ie(guest_ie), .ext_irq(ext_irq), .retire_stb(retire_stb),
        .retire_ss_load(retire_ss_load), .retire_tpr_wr(retire_tpr_wr),
        .retire_tpr_val(retire_tpr_val), .nmi_taken(nmi_taken),
        .nmi_return(nmi_return), .in_guest(in_guest), .exit_req(exit_req),
        .exit_reason(exit_reason), .tpr_shadow(tpr_shadow), .istate(istate),
        .inj_valid(inj_valid), .inj_vec(inj_vec), .inj_type(inj_type)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    // Advance one edge; inputs change and outputs are read 1 ns after it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic enter(input logic [3:0] tpr, input logic [1:0] st,
                         input logic iv, input logic [7:0] vec, input logic [2:0] typ);
        entry_stb = 1; entry_tpr = tpr; entry_istate = st;
        entry_inj_vld = iv; entry_inj_vec = vec; entry_inj_type = typ;
        tick();
        entry_stb = 0; entry_inj_vld = 0;
    endtask

    task automatic leave();
        ctl_ext_exit = 1; ext_irq = 1;
        tick();
        ctl_ext_exit = 0; ext_irq = 0;
        tick();
    endtask

    task automatic t_reset();
        chk_eq("R1 in_guest", in_guest, 0);
        chk_eq("R1 exit_req", exit_req, 0);
        chk_eq("R1 reason", exit_reason, 0);
        chk_eq("R1 shadow", tpr_shadow, 0);
        chk_eq("R1 istate", istate, 0);
        chk_eq("R1 inj_valid", inj_valid, 0);
    endtask

    task automatic t_entry_inject();
        enter(4'd5, 2'b10, 1'b1, 8'h2E, 3'd3);
        chk_eq("R2 in_guest", in_guest, 1);
        chk_eq("R2 shadow", tpr_shadow, 5);
        chk_eq("R2 istate", istate, 2);
        chk_eq("R11 inj_valid", inj_valid, 1);
        chk_eq("R11 inj_vec", inj_vec, 8'h2E);
        chk_eq("R11 inj_type", inj_type, 3);
        // R12: a second entry while in guest mode is ignored
        entry_stb = 1; entry_tpr = 4'd9; entry_istate = 2'b01; entry_inj_vld = 1;
        tick();
        entry_stb = 0; entry_inj_vld = 0;
        chk_eq("R11 inj one cycle", inj_valid, 0);
        chk_eq("R12 shadow kept", tpr_shadow, 5);
        chk_eq("R12 istate kept", istate, 2);
        leave();
        enter(4'd1, 2'b00, 1'b0, 8'h11, 3'd1);
        chk_eq("R11 no injection", inj_valid, 0);
        chk_eq("R2 reason cleared", exit_reason, 0);
        leave();
    endtask

    task automatic t_ext();
        enter(4'd0, 2'b00, 1'b0, 8'h0, 3'd0);
        guest_ie = 0; ext_irq = 1;
        tick();
        chk_eq("R3 no exit when control clear", exit_req, 0);
        ctl_ext_exit = 1;
        tick();
        chk_eq("R3 exit_req", exit_req, 1);
        chk_eq("R3 reason ext", exit_reason, 1);
        chk_eq("R10 left guest", in_guest, 0);
        tick();
        chk_eq("R10 pulse", exit_req, 0);
        tick();
        chk_eq("R10 ignored outside guest", exit_req, 0);
        chk_eq("R10 reason held", exit_reason, 1);
        ctl_ext_exit = 0; ext_irq = 0;
        tick();
    endtask

    task automatic t_window();
        enter(4'd0, 2'b01, 1'b0, 8'h0, 3'd0);
        ctl_win_exit = 1; guest_ie = 1;
        tick();
        chk_eq("R5 block holds window", exit_req, 0);
        chk_eq("R5 istate set on entry", istate, 1);
        retire_stb = 1;
        tick();
        retire_stb = 0;
        chk_eq("R5 cleared by retire", istate, 0);
        chk_eq("R4 not yet", exit_req, 0);
        tick();
        chk_eq("R4 window exit", exit_req, 1);
        chk_eq("R4 reason window", exit_reason, 3);
        guest_ie = 0;
        enter(4'd0, 2'b00, 1'b0, 8'h0, 3'd0);
        tick();
        chk_eq("R4 enable 0 blocks", exit_req, 0);
        retire_stb = 1; retire_ss_load = 1;
        tick();
        retire_stb = 0; retire_ss_load = 0;
        chk_eq("R5 set by stack load", istate, 1);
        guest_ie = 1;
        tick();
        chk_eq("R5 blocked while set", exit_req, 0);
        retire_stb = 1;
        tick();
        retire_stb = 0;
        chk_eq("R5 cleared", istate, 0);
        tick();
        chk_eq("R4 exit after clear", exit_reason, 3);
        chk_eq("R4 exit_req after clear", exit_req, 1);
        guest_ie = 0; ctl_win_exit = 0;
        tick();
    endtask

    task automatic t_nmi();
        enter(4'd0, 2'b00, 1'b0, 8'h0, 3'd0);
        nmi_taken = 1;
        tick();
        nmi_taken = 0;
        chk_eq("R6 nmi set", istate, 2);
        nmi_return = 1;
        tick();
        nmi_return = 0;
        chk_eq("R6 nmi clear", istate, 0);
        leave();
    endtask

    task automatic wr_tpr(input logic [3:0] v);
        retire_stb = 1; retire_tpr_wr = 1; retire_tpr_val = v;
        tick();
        retire_stb = 0; retire_tpr_wr = 0;
    endtask

    task automatic t_tpr();
        tpr_threshold = 4'd6; ctl_tpr_shadow = 1;
        enter(4'd8, 2'b00, 1'b0, 8'h0, 3'd0);
        wr_tpr(4'd7);
        chk_eq("R8 lower but not below threshold", exit_req, 0);
        chk_eq("R7 shadow written", tpr_shadow, 7);
        wr_tpr(4'd9);
        chk_eq("R8 raised no exit", exit_req, 0);
        chk_eq("R7 shadow raised", tpr_shadow, 9);
        wr_tpr(4'd5);
        chk_eq("R8 drop exit", exit_req, 1);
        chk_eq("R8 reason tpr", exit_reason, 2);
        chk_eq("R7 shadow after drop", tpr_shadow, 5);
        enter(4'd3, 2'b00, 1'b0, 8'h0, 3'd0);
        wr_tpr(4'd3);
        chk_eq("R8 unchanged below threshold", exit_req, 0);
        wr_tpr(4'd4);
        chk_eq("R8 raised below threshold", exit_req, 0);
        ctl_tpr_shadow = 0;
        wr_tpr(4'd1);
        chk_eq("R7 disabled shadow kept", tpr_shadow, 4);
        chk_eq("R7 disabled no exit", exit_req, 0);
        leave();
    endtask

    task automatic t_prio();
        tpr_threshold = 4'd6; ctl_tpr_shadow = 1; ctl_win_exit = 1; guest_ie = 1;
        ctl_ext_exit = 1;
        enter(4'd8, 2'b00, 1'b0, 8'h0, 3'd0);
        ext_irq = 1;
        wr_tpr(4'd2);
        ext_irq = 0;
        chk_eq("R9 ext wins", exit_reason, 1);
        enter(4'd8, 2'b00, 1'b0, 8'h0, 3'd0);
        wr_tpr(4'd2);
        chk_eq("R9 tpr over window", exit_reason, 2);
        chk_eq("R9 single pulse", exit_req, 1);
        ctl_tpr_shadow = 0; ctl_win_exit = 0; guest_ie = 0; ctl_ext_exit = 0;
        tick();
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1;
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_entry_inject();
        t_ext();
        t_window();
        t_nmi();
        t_tpr();
        t_prio();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule